// File: doc/BRIEF.md
# Wishbone Prefetching Read Slave with Retry

This block is a read-only Wishbone slave placed in front of a slow back end. It answers reads out of a small prefetch buffer. When a read arrives and no prefetch stream is running, or the address is not the one the stream expects, the slave answers with a one-cycle retry. It then starts fetching consecutive words from the requested word address over a simple request/valid back-end port. When the master comes back, it receives the buffered word with an acknowledge.

A master that holds the burst qualifier high streams the buffered words, one per strobe, while the slave keeps refilling behind it. A master that reads with the burst qualifier low takes one word. The rest of the buffer is then thrown away and fetching stops, so the next read starts a new stream. A flushed word is never delivered late; it is fetched again when it is asked for. The slave needs only the strobe and the burst qualifier to frame transfers, so cycle may be tied high in a point-to-point connection. Writes are answered with an error response.

Addresses are word addresses. All responses are registered: a strobe sampled at one clock edge is answered for exactly one cycle after that edge.

Top module: `wb_prefetch_rd`

## Requirements
- R1: A read strobe taken while no prefetch stream is active (after reset or after a flush) is answered with a retry that lasts one cycle, and the first back-end request then carries the strobe's word address.
- R2: Every strobe sampled while cycle is high and no response is showing gets exactly one of ack, retry or error in the next cycle, for one cycle. A strobe sampled during a response cycle gets no response of its own.
- R3: be_req_o is a one-cycle pulse, with at most one request outstanding. A request is issued only while fewer than DEPTH (4) words are buffered, and the request addresses follow one another. Each accepted be_vld_i stores one word. With no reads, a new stream stops after exactly 4 requests.
- R4: A read whose address equals the stream's expected address, with a word buffered, is acknowledged with the back-end word for that address, and the expected address advances by one.
- R5: With the burst qualifier held high, a full buffer delivers four consecutive strobes without retry, and refilling continues so that longer bursts return correct data.
- R6: When a read is acknowledged with the burst qualifier low, the remaining buffered words are discarded and fetching stops. The next read, even at the following address, gets a retry.
- R7: A falling burst qualifier, or cycle low, flushes the buffer and ends the stream. The next read gets a retry.
- R8: A read at an address other than the expected one flushes the buffer, gets a retry and restarts fetching at the new address.
- R9: A back-end word that answers a request issued before a flush is discarded and never delivered.
- R10: A write strobe gets an error response and leaves the buffer and the stream untouched.
- R11: Synchronous reset clears all responses, empties the buffer, clears any outstanding request and stops the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle active (may be tied high) |
| wb_stb_i | input | 1 | Strobe |
| wb_burst_i | input | 1 | Burst qualifier, held high across a burst |
| wb_we_i | input | 1 | Write enable (writes are answered with error) |
| wb_adr_i | input | AW (16) | Word address |
| wb_dat_o | output | DW (32) | Read data, valid with ack |
| wb_ack_o | output | 1 | Acknowledge |
| wb_rty_o | output | 1 | Retry |
| wb_err_o | output | 1 | Error |
| be_req_o | output | 1 | Back-end fetch request pulse |
| be_adr_o | output | AW (16) | Back-end fetch word address |
| be_vld_i | input | 1 | Back-end data valid |
| be_dat_i | input | DW (32) | Back-end data |

## Verification
The assertions assume a back end that answers each request with exactly one valid pulse, at least one cycle after the request is seen and before any later request. The bench's memory model keeps a single slot, replies after a latency of one to six cycles and is cleared on reset. The assertions also assume that the master keeps strobe, address and burst qualifier stable until a response appears and drops the strobe in the cycle of the response. The bench master does exactly that. A per-cycle reference model built on a data queue predicts every response, every data word and every back-end request.

// File: rtl/wb_prefetch_pkg.sv
package wb_prefetch_pkg;
    // Kind of answer given to one sampled strobe
    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_ACK  = 2'd1,
        RSP_RTY  = 2'd2,
        RSP_ERR  = 2'd3
    } rsp_e;
endpackage

// File: rtl/wb_prefetch_buf.sv
// Prefetch word store: circular buffer with flush, one push and one pop per cycle.
module wb_prefetch_buf #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_dat,
    input  logic          pop,
    output logic [DW-1:0] head_dat,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          p_d, p_q;
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        p_d   = p_q;
        mem_d = mem_q;
        if (flush) begin
            p_d = '0;
        end else begin
            if (pop) begin
                p_d.rd = p_q.rd + 1'b1;
            end
            if (push) begin
                mem_d[p_q.wr] = push_dat;
                p_d.wr        = p_q.wr + 1'b1;
            end
            p_d.cnt = p_q.cnt + {{(CW-1){1'b0}}, push} - {{(CW-1){1'b0}}, pop};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign head_dat = mem_q[p_q.rd];
    assign count    = p_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush) |-> (p_q.cnt < FULL)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (pop && !flush) |-> (p_q.cnt != '0)); // R4
endmodule

// File: rtl/wb_prefetch_fetch.sv
// Back-end fetch engine: one outstanding request, discards words orphaned by a flush.
module wb_prefetch_fetch #(
    parameter int AW    = 16,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_adr,
    input  logic          stop,
    input  logic          flush,
    input  logic [CW-1:0] cnt,
    input  logic          be_vld_i,
    output logic          active,
    output logic          push,
    output logic          be_req_o,
    output logic [AW-1:0] be_adr_o
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic          active;
        logic          pend;
        logic          drop;
        logic          req;
        logic [AW-1:0] fadr;
        logic [AW-1:0] radr;
    } fet_t;

    fet_t s_d, s_q;
    logic vld_ok;

    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        push    = 1'b0;
        vld_ok  = be_vld_i && s_q.pend;

        // returning word: keep it only if no flush has orphaned it
        if (vld_ok) begin
            push     = !s_q.drop && !flush;
            s_d.pend = 1'b0;
            s_d.drop = 1'b0;
        end else if (flush && s_q.pend) begin
            s_d.drop = 1'b1;
        end

        if (start) begin
            s_d.active = 1'b1;
            s_d.fadr   = start_adr;
        end else if (stop) begin
            s_d.active = 1'b0;
        end

        if (s_q.active && !flush && !s_q.pend && (cnt < FULL)) begin
            s_d.req  = 1'b1;
            s_d.pend = 1'b1;
            s_d.radr = s_q.fadr;
            s_d.fadr = s_q.fadr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign active   = s_q.active;
    assign be_req_o = s_q.req;
    assign be_adr_o = s_q.radr;

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        be_req_o |=> !be_req_o); // R3
endmodule

// File: rtl/wb_prefetch_rd.sv
// Read-only Wishbone slave answering from a prefetch buffer, retrying while it fills.
module wb_prefetch_rd #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wb_cyc_i,
    input  logic          wb_stb_i,
    input  logic          wb_burst_i,
    input  logic          wb_we_i,
    input  logic [AW-1:0] wb_adr_i,
    output logic [DW-1:0] wb_dat_o,
    output logic          wb_ack_o,
    output logic          wb_rty_o,
    output logic          wb_err_o,
    output logic          be_req_o,
    output logic [AW-1:0] be_adr_o,
    input  logic          be_vld_i,
    input  logic [DW-1:0] be_dat_i
);
    import wb_prefetch_pkg::*;

    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic          ack;
        logic          rty;
        logic          err;
        logic          burst;
        logic [AW-1:0] exp;
        logic [DW-1:0] dat;
    } rsp_t;

    rsp_t          r_d, r_q;
    rsp_e          kind;
    logic          busy, end_evt, take, hit;
    logic          start, stop, flush, pop, push;
    logic          fe_active;
    logic [CW-1:0] buf_cnt;
    logic [DW-1:0] buf_head;

    always_comb begin
        r_d       = r_q;
        r_d.ack   = 1'b0;
        r_d.rty   = 1'b0;
        r_d.err   = 1'b0;
        r_d.burst = wb_burst_i;

        busy    = r_q.ack || r_q.rty || r_q.err;
        end_evt = !wb_cyc_i || (r_q.burst && !wb_burst_i);
        take    = wb_cyc_i && wb_stb_i && !busy;
        hit     = fe_active && !end_evt && (wb_adr_i == r_q.exp);

        kind  = RSP_NONE;
        start = 1'b0;
        pop   = 1'b0;
        if (take) begin
            if (wb_we_i) begin
                kind = RSP_ERR;
            end else if (hit && (buf_cnt != '0)) begin
                kind = RSP_ACK;
            end else begin
                kind  = RSP_RTY;
                start = !hit;
            end
        end

        unique case (kind)
            RSP_ACK: begin
                r_d.ack = 1'b1;
                r_d.dat = buf_head;
                r_d.exp = r_q.exp + 1'b1;
                pop     = 1'b1;
            end
            RSP_RTY: begin
                r_d.rty = 1'b1;
                if (start) r_d.exp = wb_adr_i;
            end
            RSP_ERR: r_d.err = 1'b1;
            default: ;
        endcase

        stop  = end_evt || ((kind == RSP_ACK) && !wb_burst_i);
        flush = stop || start;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    wb_prefetch_fetch #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_adr (wb_adr_i),
        .stop      (stop),
        .flush     (flush),
        .cnt       (buf_cnt),
        .be_vld_i  (be_vld_i),
        .active    (fe_active),
        .push      (push),
        .be_req_o  (be_req_o),
        .be_adr_o  (be_adr_o)
    );

    wb_prefetch_buf #(.DW(DW), .DEPTH(DEPTH), .PW(PW), .CW(CW)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .push     (push),
        .push_dat (be_dat_i),
        .pop      (pop),
        .head_dat (buf_head),
        .count    (buf_cnt)
    );

    assign wb_ack_o = r_q.ack;
    assign wb_rty_o = r_q.rty;
    assign wb_err_o = r_q.err;
    assign wb_dat_o = r_q.dat;

    AST_RTY_PULSE: assert property (@(posedge clk) disable iff (rst)
        wb_rty_o |=> !wb_rty_o); // R1
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wb_ack_o, wb_rty_o, wb_err_o})); // R2
    AST_RESP_GAP: assert property (@(posedge clk) disable iff (rst)
        (wb_ack_o || wb_rty_o || wb_err_o) |=> !(wb_ack_o || wb_rty_o || wb_err_o)); // R2
    AST_REQ_ROOM: assert property (@(posedge clk) disable iff (rst)
        be_req_o |-> (buf_cnt < FULL)); // R3
    AST_SINGLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (wb_ack_o && !$past(wb_burst_i)) |-> (buf_cnt == '0)); // R6
    AST_CYC_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !wb_cyc_i |=> (buf_cnt == '0)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (buf_cnt == '0 && !wb_ack_o && !wb_rty_o && !wb_err_o && !be_req_o)); // R11
endmodule

// File: tb/test_wb_prefetch_rd.sv
module test_wb_prefetch_rd;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b1, stb = 1'b0, burst = 1'b0, we = 1'b0;
    logic [15:0] adr = '0;
    logic [31:0] dat;
    logic        ack, rty, err, breq, vld = 1'b0;
    logic [15:0] badr;
    logic [31:0] bdat = '0;

    int nchk = 0, nerr = 0, ncyc = 0;
    bit started = 0, done = 0;

    always #5 clk = ~clk;

    wb_prefetch_rd i_wb_prefetch_rd (
        .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_burst_i(burst),
        .wb_we_i(we), .wb_adr_i(adr), .wb_dat_o(dat), .wb_ack_o(ack), .wb_rty_o(rty),
        .wb_err_o(err), .be_req_o(breq), .be_adr_o(badr), .be_vld_i(vld), .be_dat_i(bdat)
    );

    function automatic logic [31:0] memf(input logic [15:0] a);
        return {~a, a} ^ 32'h1234_0000;
    endfunction

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // ---------------- back-end memory model ----------------
    bit   bk_busy = 0, bk_long = 0;
    int   bk_cnt = 0, bk_n = 0;
    logic [15:0] bk_adr;
    always @(negedge clk) begin
        vld <= 1'b0;
        if (rst) begin
            bk_busy = 0;
        end else begin
            if (bk_busy) begin
                if (bk_cnt <= 1) begin
                    vld     <= 1'b1;
                    bdat    <= memf(bk_adr);
                    bk_busy = 0;
                end else bk_cnt--;
            end
            if (breq) begin
                bk_busy = 1;
                bk_adr  = badr;
                bk_cnt  = bk_long ? 6 : 1 + (bk_n % 3);
                bk_n++;
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    logic        m_ack = 0, m_rty = 0, m_err = 0, m_cab = 0, m_act = 0, m_pend = 0, m_drop = 0, m_req = 0;
    logic [31:0] m_dat = '0;
    logic [15:0] m_exp = '0, m_fadr = '0, m_radr = '0;
    logic [31:0] mq[$];

    always @(posedge clk) begin : model
        bit busy, endv, take, hit, na, nr, ne, st, stop, fl, o_act, o_pend, o_drop;
        int o_size;
        logic [15:0] o_fadr;
        if (rst) begin
            m_ack = 0; m_rty = 0; m_err = 0; m_cab = 0; m_act = 0;
            m_pend = 0; m_drop = 0; m_req = 0; mq.delete();
        end else begin
            busy = m_ack | m_rty | m_err;
            endv = !cyc || (m_cab && !burst);
            take = cyc && stb && !busy;
            hit  = m_act && !endv && (adr == m_exp);
            na = 0; nr = 0; ne = 0; st = 0;
            if (take) begin
                if (we) ne = 1;
                else if (hit && mq.size() > 0) na = 1;
                else begin nr = 1; st = !hit; end
            end
            stop = endv || (na && !burst);
            fl   = stop || st;
            o_size = mq.size(); o_act = m_act; o_pend = m_pend; o_drop = m_drop; o_fadr = m_fadr;
            if (na) begin m_dat = mq.pop_front(); m_exp = m_exp + 16'd1; end
            if (st) m_exp = adr;
            if (vld && o_pend) begin
                if (!o_drop && !fl) mq.push_back(bdat);
                m_pend = 0; m_drop = 0;
            end else if (fl && o_pend) m_drop = 1;
            if (fl) mq.delete();
            if (st) begin m_act = 1; m_fadr = adr; end
            else if (stop) m_act = 0;
            m_req = 0;
            if (o_act && !fl && !o_pend && o_size < 4) begin
                m_req = 1; m_pend = 1; m_radr = o_fadr; m_fadr = o_fadr + 16'd1;
            end
            m_ack = na; m_rty = nr; m_err = ne; m_cab = burst;
        end
        started = 1;
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            chk(ack == m_ack && rty == m_rty && err == m_err, "R2 response",
                {29'd0, ack, rty, err}, {29'd0, m_ack, m_rty, m_err});
            if (m_ack) chk(dat == m_dat, "R4 data", dat, m_dat);
            chk(breq == m_req, "R3 request", {31'd0, breq}, {31'd0, m_req});
            if (m_req) chk(badr == m_radr, "R3 request address", {16'd0, badr}, {16'd0, m_radr});
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        ncyc++;
        if (ncyc == 100000 && !done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0d expected<%0d", ncyc, 100000);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    // ---------------- master tasks ----------------
    task automatic rd(input logic [15:0] a, input logic c, input logic w, output int kind, output logic [31:0] d);
        @(negedge clk);
        stb = 1; we = w; adr = a; burst = c;
        kind = 0; d = '0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ack)      begin kind = 1; d = dat; break; end
            else if (rty) begin kind = 2; break; end
            else if (err) begin kind = 3; break; end
        end
        stb = 0; we = 0;
    endtask

    task automatic rd_ack(input logic [15:0] a, input logic c, output int tries, output logic [31:0] d);
        int k;
        tries = 0;
        for (int i = 0; i < 100; i++) begin
            rd(a, c, 0, k, d);
            if (k == 1) break;
            tries++;
        end
    endtask

    task automatic idle(input int n, output int nreq, output logic [15:0] first, output logic [15:0] last);
        nreq = 0; first = '0; last = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (breq) begin
                if (nreq == 0) first = badr;
                last = badr;
                nreq++;
            end
        end
    endtask

    initial begin
        int k, t, nreq;
        logic [31:0] d;
        logic [15:0] f, l;

        repeat (3) @(negedge clk);
        chk(!ack && !rty && !err && !breq, "R11 reset state", {28'd0, ack, rty, err, breq}, 32'd0);
        rst = 0;

        // single read from idle
        rd(16'h0010, 0, 0, k, d);
        chk(k == 2, "R1 first read retried", k, 2);
        idle(8, nreq, f, l);
        chk(nreq > 0 && f == 16'h0010, "R1 fetch starts at strobe address", {16'd0, f}, 32'h10);
        rd_ack(16'h0010, 0, t, d);
        chk(d == memf(16'h0010), "R4 single read data", d, memf(16'h0010));

        // leftovers discarded, fetching stopped
        idle(10, nreq, f, l);
        chk(nreq == 0, "R6 fetching stops after single read", nreq, 0);
        rd(16'h0011, 0, 0, k, d);
        chk(k == 2, "R6 next read retried", k, 2);
        rd_ack(16'h0011, 0, t, d);
        chk(d == memf(16'h0011), "R6 refetched word", d, memf(16'h0011));

        // fill to depth, then burst
        rd(16'h0040, 1, 0, k, d);
        chk(k == 2, "R1 burst start retried", k, 2);
        idle(30, nreq, f, l);
        chk(nreq == 4, "R3 exactly four requests", nreq, 4);
        chk(f == 16'h0040 && l == 16'h0043, "R3 consecutive addresses", {f, l}, 32'h0040_0043);
        for (int i = 0; i < 10; i++) begin
            rd_ack(16'h0040 + 16'(i), 1, t, d);
            if (i < 4) chk(t == 0, "R5 buffered word without retry", t, 0);
            chk(d == memf(16'h0040 + 16'(i)), "R5 burst data", d, memf(16'h0040 + 16'(i)));
        end

        // burst qualifier falls: flush
        idle(30, nreq, f, l);
        @(negedge clk); burst = 0;
        rd(16'h004A, 1, 0, k, d);
        chk(k == 2, "R7 burst end flushes", k, 2);
        rd_ack(16'h004A, 1, t, d);
        chk(d == memf(16'h004A), "R7 refetch data", d, memf(16'h004A));

        // address mismatch
        idle(30, nreq, f, l);
        rd(16'h0060, 1, 0, k, d);
        chk(k == 2, "R8 mismatch retried", k, 2);
        idle(30, nreq, f, l);
        chk(f == 16'h0060, "R8 restart address", {16'd0, f}, 32'h60);
        rd_ack(16'h0060, 1, t, d);
        chk(t == 0 && d == memf(16'h0060), "R8 new stream data", d, memf(16'h0060));

        // write gets error, buffer untouched
        idle(30, nreq, f, l);
        rd(16'h0061, 1, 1, k, d);
        chk(k == 3, "R10 write answered with error", k, 3);
        rd_ack(16'h0061, 1, t, d);
        chk(t == 0, "R10 buffer kept after write", t, 0);
        chk(d == memf(16'h0061), "R10 data after write", d, memf(16'h0061));

        // stale word from orphaned request
        idle(30, nreq, f, l);
        bk_long = 1;
        rd(16'h0080, 1, 0, k, d);
        rd(16'h0090, 1, 0, k, d);
        chk(k == 2, "R9 switch retried", k, 2);
        rd_ack(16'h0090, 1, t, d);
        chk(d == memf(16'h0090), "R9 no stale data", d, memf(16'h0090));
        rd_ack(16'h0091, 1, t, d);
        chk(d == memf(16'h0091), "R9 following word", d, memf(16'h0091));
        bk_long = 0;

        // cycle low flush
        idle(40, nreq, f, l);
        @(negedge clk); cyc = 0;
        @(negedge clk); cyc = 1;
        rd(16'h0092, 1, 0, k, d);
        chk(k == 2, "R7 cycle low flushes", k, 2);

        // reset in mid stream
        idle(3, nreq, f, l);
        rst = 1;
        repeat (2) @(negedge clk);
        chk(!ack && !rty && !err && !breq, "R11 mid reset outputs", {28'd0, ack, rty, err, breq}, 32'd0);
        rst = 0;
        rd_ack(16'h0093, 1, t, d);
        chk(t >= 1, "R11 stream cleared by reset", t, 1);
        chk(d == memf(16'h0093), "R11 data after reset", d, memf(16'h0093));

        @(negedge clk); burst = 0;
        repeat (5) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule